// File: doc/BRIEF.md
# Synchronous Slot-Timed Bus Master and Memory Slave

This block joins a bus master to a small register-array memory slave over a shared synchronous bus. The bus has no handshake. Every event sits in a numbered clock slot, and both ends count the slots the same way. A requester hands the master a read or a write through a valid/ready request port. The master then runs one transfer of three slots.

- **Slot 1:** the master puts the address on the bus. It raises the address strobe half a clock later, once the address has settled.
- **Slot 2, read:** the master raises the read command at the start of the slot.
- **Slot 2, write:** the master drives the data lines at the start of the slot and raises the write command half a clock later.
- **Slot 3, read:** the slave drives the addressed word one slot after the read command, and the master samples it at the end of the slot.
- **Slot 3, write:** the slave copies the data lines into its array at the end of the slot.
- **After slot 3:** the bus goes idle and the master gives a one-cycle done pulse, with the read data, to the requester.

The slave answers only inside its configured address window. Outside it the slave never enables its data drivers, and an undriven bus reads as zero.

The request port applies back-pressure through `req_ready`. It is high only when no transfer is running and no done pulse is showing. `req_valid` raised while `req_ready` is low has no effect. The requester must hold its request until a cycle in which both are high. The response is a plain pulse with no back-pressure.

Top module: `sbus_system`

## Requirements
- R1: While reset is held and right after it, all bus lines, both data enables and `rsp_done` are low, `bus_addr` is zero and `req_ready` is high.
- R2: In slot 1, the cycle after a request is accepted, `bus_addr` carries the request address. `bus_aen` is low in the first half of the slot and high in the second half, and it stays high through slot 3.
- R3: For a read, `bus_rd` is high for all of slots 2 and 3, and `bus_wr` and `bus_m_oe` stay low.
- R4: For a read inside the window, the slave drives the addressed word in slot 3 only: `bus_s_oe` is high and `bus_data` equals the stored word. The two data enables are never high together.
- R5: For a write, `bus_m_oe` is high with the write data on `bus_data` for all of slots 2 and 3. `bus_wr` is low in the first half of slot 2 and high from its second half through slot 3. `bus_rd` stays low.
- R6: A write inside the window is stored at the end of slot 3, and a later read of that address returns it.
- R7: For an address outside the window, `bus_s_oe` stays low, a read returns zero, and a write changes no stored word, including the word whose index it would alias.
- R8: `rsp_done` is high for exactly the one cycle after slot 3. In that cycle `rsp_rdata` holds the sampled read data, or zero for a write. `req_ready` is low from acceptance through the done cycle and high again in the following cycle.
- R9: `req_valid` raised while `req_ready` is low starts no transfer and changes no stored word.
- R10: In the cycle after slot 3, the following are all low and `bus_addr` is zero:
  - `bus_aen`
  - `bus_rd`
  - `bus_wr`
  - `bus_m_oe`
  - `bus_s_oe`
- R11: The window covers `BASE_ADDR` up to `BASE_ADDR + DEPTH - 1` inclusive. Both end addresses hit, and the address just below and the address just above miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; slots run from rising edge to rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle pulse at the end of a transfer |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_done` |
| bus_addr | output | ADDR_W | Address lines, driven in slots 1 to 3 |
| bus_aen | output | 1 | Address strobe |
| bus_rd | output | 1 | Read command |
| bus_wr | output | 1 | Write command |
| bus_data | output | DATA_W | Resolved data lines (zero when undriven) |
| bus_m_oe | output | 1 | Master drives the data lines |
| bus_s_oe | output | 1 | Slave drives the data lines |

## Verification
The bench builds the block with its defaults: 8-bit addresses, 16-bit data, a 16-word array and a window based at 0x40. These values keep both window edges, and the addresses just past them, in easy reach of directed tests. The whole array can be filled and read back in a few hundred cycles. An address below the window whose low bits alias index 0 can show that a stray write would corrupt a known word. Sampling in both half-cycles of each slot separates the half-clock strobes from the full-slot commands.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_1    = 2'd1,
    SLOT_2    = 2'd2,
    SLOT_3    = 2'd3
  } slot_e;
endpackage

// File: rtl/sbus_mem.sv
module sbus_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cells[g] <= '0;
      else if (we && widx == IDX_W'(g))        cells[g] <= wdata;
    end
  end

  assign rdata = cells[ridx];
endmodule

// File: rtl/sbus_master.sv
module sbus_master
  import sbus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_aen,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_doe,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);
  slot_e             slot_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              aen_half_q;
  logic              wr_half_q;
  logic              busy;
  logic              data_slot;

  assign busy      = (slot_q != SLOT_IDLE);
  assign data_slot = (slot_q == SLOT_2) || (slot_q == SLOT_3);
  assign req_ready = (slot_q == SLOT_IDLE) && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= SLOT_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (slot_q)
        SLOT_IDLE: if (req_valid && req_ready) begin
          slot_q  <= SLOT_1;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          write_q <= req_write;
        end
        SLOT_1: slot_q <= SLOT_2;
        SLOT_2: slot_q <= SLOT_3;
        SLOT_3: begin
          slot_q  <= SLOT_IDLE;
          done_q  <= 1'b1;
          rdata_q <= write_q ? '0 : bus_din;
        end
        default: slot_q <= SLOT_IDLE;
      endcase
    end
  end

  // Strobes that must wait for settled lines rise on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aen_half_q <= 1'b0;
      wr_half_q  <= 1'b0;
    end else begin
      aen_half_q <= busy;
      wr_half_q  <= write_q && data_slot;
    end
  end

  assign bus_addr  = busy ? addr_q : '0;
  assign bus_aen   = aen_half_q && busy;
  assign bus_wr    = wr_half_q && busy;
  assign bus_rd    = !write_q && data_slot;
  assign bus_doe   = write_q && data_slot;
  assign bus_dout  = bus_doe ? wdata_q : '0;
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> req_ready);
  a_r3_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  a_r10_idle_after_slot3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SLOT_3) |=> !(bus_rd || bus_wr || bus_aen || bus_doe));
  a_r9_busy_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(addr_q));
endmodule

// File: rtl/sbus_slave.sv
module sbus_slave #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 16,
  parameter int              DEPTH     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_aen,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_soe,
  output logic [DATA_W-1:0] bus_sdout
);
  localparam logic [ADDR_W:0] WIN_LO = {1'b0, BASE_ADDR};
  localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'(DEPTH);

  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] offs;
  logic              drive_q;
  logic [DATA_W-1:0] dout_q;
  logic              wr_seen_q;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rdata;

  assign hit  = ({1'b0, bus_addr} >= WIN_LO) && ({1'b0, bus_addr} < WIN_HI);
  assign offs = bus_addr - BASE_ADDR;
  assign idx  = offs[IDX_W-1:0];
  // Second edge that sees the write command closes slot 3
  assign mem_we = bus_wr && bus_aen && hit && wr_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q   <= 1'b0;
      dout_q    <= '0;
      wr_seen_q <= 1'b0;
    end else begin
      drive_q   <= bus_rd && bus_aen && hit && !drive_q;
      dout_q    <= (bus_rd && bus_aen && hit && !drive_q) ? mem_rdata : '0;
      wr_seen_q <= bus_wr && !wr_seen_q;
    end
  end

  sbus_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .widx(idx),
    .wdata(bus_din), .ridx(idx), .rdata(mem_rdata)
  );

  assign bus_soe   = drive_q;
  assign bus_sdout = dout_q;

  a_r4_oe_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_soe |-> (bus_rd && bus_aen));
  a_r7_oe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    bus_soe |-> $past(hit));
  a_r6_store_after_cmd_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(bus_wr));
endmodule

// File: rtl/sbus_system.sv
module sbus_system #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 16,
  parameter int              DEPTH     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_aen,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_m_oe,
  output logic              bus_s_oe
);
  logic [DATA_W-1:0] m_dout;
  logic [DATA_W-1:0] s_dout;

  sbus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_aen(bus_aen), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_doe(bus_m_oe), .bus_dout(m_dout), .bus_din(bus_data)
  );

  sbus_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
               .BASE_ADDR(BASE_ADDR)) u_slave (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_aen(bus_aen), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_din(bus_data), .bus_soe(bus_s_oe), .bus_sdout(s_dout)
  );

  // Resolved data lines; an undriven bus reads as zero
  assign bus_data = bus_m_oe ? m_dout : (bus_s_oe ? s_dout : '0);

  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_m_oe && bus_s_oe));
endmodule

// File: tb/sbus_system_bench.sv
module sbus_system_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam logic [AW-1:0] BASE = 8'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_done, bus_aen, bus_rd, bus_wr, bus_m_oe, bus_s_oe;
  logic [DW-1:0] rsp_rdata, bus_data;
  logic [AW-1:0] bus_addr;

  int n_checks = 0;
  int n_fail = 0;
  logic [DW-1:0] model [DEPTH];

  always #5 clk = ~clk;

  sbus_system #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .BASE_ADDR(BASE)) u_sbus_system (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_aen(bus_aen), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_data(bus_data),
    .bus_m_oe(bus_m_oe), .bus_s_oe(bus_s_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  function automatic bit in_win(input logic [AW-1:0] a);
    return (a >= BASE) && ({1'b0, a} < ({1'b0, BASE} + 9'(DEPTH)));
  endfunction

  // One full transfer, checked in both halves of every slot
  task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit poke_busy);
    logic [DW-1:0] exp_rd;
    logic [3:0] ix;
    bit hit;
    hit = in_win(a);
    ix = 4'(a - BASE);
    exp_rd = (!wr && hit) ? model[ix] : '0;
    @(posedge clk); #1;
    check(req_ready == 1'b1, "R8 ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    #1; // slot 1, first half
    check(bus_addr == a, "R2 address in slot1", 32'(bus_addr), 32'(a));
    check(bus_aen == 1'b0, "R2 aen low first half", 32'(bus_aen), 0);
    check(!bus_rd && !bus_wr && !bus_m_oe, "R2 no command slot1", 32'({bus_rd, bus_wr, bus_m_oe}), 0);
    check(req_ready == 1'b0, "R8 ready low while busy", 32'(req_ready), 0);
    #5; // slot 1, second half
    check(bus_aen == 1'b1, "R2 aen high second half", 32'(bus_aen), 1);
    check(!bus_wr && !bus_rd, "R2 no command slot1 late", 32'({bus_rd, bus_wr}), 0);
    @(posedge clk); #1;
    if (poke_busy) begin
      req_valid = 1'b1; req_write = 1'b1; req_addr = BASE + 8'h5; req_wdata = 16'hDEAD;
    end
    #1; // slot 2, first half
    if (wr) begin
      check(bus_m_oe && bus_data == d, "R5 data driven slot2", 32'(bus_data), 32'(d));
      check(bus_wr == 1'b0, "R5 wr low first half slot2", 32'(bus_wr), 0);
      check(bus_rd == 1'b0, "R5 no read cmd", 32'(bus_rd), 0);
    end else begin
      check(bus_rd == 1'b1, "R3 rd at slot2 start", 32'(bus_rd), 1);
      check(!bus_wr && !bus_m_oe, "R3 no write side", 32'({bus_wr, bus_m_oe}), 0);
      check(bus_s_oe == 1'b0, "R4 slave quiet in slot2", 32'(bus_s_oe), 0);
    end
    check(bus_aen == 1'b1 && bus_addr == a, "R2 aen and address held slot2", 32'({bus_aen, bus_addr}), 32'({1'b1, a}));
    #5;
    if (wr) check(bus_wr == 1'b1, "R5 wr high second half slot2", 32'(bus_wr), 1);
    @(posedge clk); #2; // slot 3
    if (wr) begin
      check(bus_m_oe && bus_wr && bus_data == d, "R5 write held slot3", 32'(bus_data), 32'(d));
      check(bus_s_oe == 1'b0, "R4 slave not driving on write", 32'(bus_s_oe), 0);
    end else begin
      check(bus_rd == 1'b1, "R3 rd held slot3", 32'(bus_rd), 1);
      check(bus_s_oe == hit, "R4 R7 slave enable follows window", 32'(bus_s_oe), 32'(hit));
      check(bus_data == exp_rd, "R4 data on bus slot3", 32'(bus_data), 32'(exp_rd));
    end
    @(posedge clk); #2; // cycle after slot 3
    if (poke_busy) req_valid = 1'b0;
    check(rsp_done == 1'b1, "R8 done pulse", 32'(rsp_done), 1);
    check(rsp_rdata == exp_rd, "R8 response data", 32'(rsp_rdata), 32'(exp_rd));
    check(req_ready == 1'b0, "R8 ready low in done cycle", 32'(req_ready), 0);
    check(!bus_aen && !bus_rd && !bus_wr && !bus_m_oe && !bus_s_oe && bus_addr == '0,
          "R10 bus idle after slot3", 32'({bus_aen, bus_rd, bus_wr, bus_m_oe, bus_s_oe, bus_addr}), 0);
    @(posedge clk); #2;
    check(rsp_done == 1'b0, "R8 done single cycle", 32'(rsp_done), 0);
    check(req_ready == 1'b1, "R8 ready again", 32'(req_ready), 1);
    if (poke_busy)
      check(bus_addr == '0 && !bus_aen, "R9 busy request started nothing", 32'(bus_addr), 0);
    if (wr && hit) model[ix] = d;
  endtask

  task automatic t_reset();
    check(!bus_aen && !bus_rd && !bus_wr && !bus_m_oe && !bus_s_oe && !rsp_done,
          "R1 lines low in reset", 32'({bus_aen, bus_rd, bus_wr, bus_m_oe, bus_s_oe, rsp_done}), 0);
    check(bus_addr == '0, "R1 address zero", 32'(bus_addr), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #2;
    check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    check(!rsp_done && !bus_aen, "R1 idle after reset", 32'({rsp_done, bus_aen}), 0);
  endtask

  task automatic t_basic();
    run_txn(1'b1, BASE + 8'h3, 16'h1234, 1'b0); // R6
    run_txn(1'b0, BASE + 8'h3, '0, 1'b0);
    run_txn(1'b1, BASE + 8'h7, 16'hFFFF, 1'b0);
    run_txn(1'b0, BASE + 8'h7, '0, 1'b0);
    run_txn(1'b0, BASE + 8'h2, '0, 1'b0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < DEPTH; i++)
      run_txn(1'b1, BASE + 8'(i), 16'hA500 ^ 16'(i * 16'h0111), 1'b0);
    for (int i = 0; i < DEPTH; i++)
      run_txn(1'b0, BASE + 8'(i), '0, 1'b0); // R6 readback
  endtask

  task automatic t_edges();
    // R11: both ends hit, neighbours miss
    run_txn(1'b0, BASE, '0, 1'b0);
    run_txn(1'b0, BASE + 8'(DEPTH - 1), '0, 1'b0);
    run_txn(1'b0, BASE - 8'h1, '0, 1'b0);
    run_txn(1'b0, BASE + 8'(DEPTH), '0, 1'b0);
  endtask

  task automatic t_outside();
    // R7: 0x30 aliases index 0 in its low bits
    run_txn(1'b1, 8'h30, 16'hBEEF, 1'b0);
    run_txn(1'b1, BASE + 8'(DEPTH), 16'hBEEF, 1'b0);
    run_txn(1'b0, BASE, '0, 1'b0);
    run_txn(1'b0, 8'h30, '0, 1'b0);
  endtask

  task automatic t_busy_ignore();
    // R9: request raised mid-transfer, dropped before ready returns
    run_txn(1'b0, BASE + 8'h9, '0, 1'b1);
    run_txn(1'b0, BASE + 8'h5, '0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    #2;
    t_reset();
    t_basic();
    t_sweep();
    t_edges();
    t_outside();
    t_busy_ignore();
    finish_run();
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end
endmodule